// File: doc/BRIEF.md
# Receive Address Filter with Loadable Match Table

This block decides, for every incoming Ethernet frame, whether the receiver keeps it. It looks at the six destination address bytes, the frame length without the CRC, and four mode inputs. The result is registered and comes out one cycle later as an accept flag with a multicast tag and a broadcast tag. The tests run in a fixed order and the first one that applies decides: short frame, promiscuous unicast, all-multicast, broadcast, and last a search of a 16-entry table of 48-bit addresses. Each table entry takes part in the search only when its bit in a 16-bit enable mask is set.

The table and the mask are loaded from memory by a short walk over descriptors, started with a one-cycle command. The walk reads one 16-bit word per request/acknowledge handshake. A count gives the number of descriptors. Each descriptor fills one entry, in index order from entry 0. After the last descriptor, one more word is read and becomes the enable mask. Software can read the table back one byte pair at a time, but only while the receiver is held in reset mode.

Top module: `rx_addr_filter`

## Requirements
- R1: A frame with `frm_len` below 60 is accepted exactly when `mode_runt_ok` is 1, carries no tag, and this test comes before every other test. A length of 60 is not short.
- R2: When `mode_promisc` is 1, a frame whose destination byte 0 (`frm_dst[7:0]`) has bit 0 clear is accepted with no tag. Promiscuous mode alone does not accept a frame with that bit set.
- R3: When `mode_all_mcast` is 1, a frame with `frm_dst[0]` set is accepted with the multicast tag. This also applies to the all-ones address, so the multicast tag wins over the broadcast tag.
- R4: When `mode_bcast` is 1 and no earlier test applies, a destination of all ones is accepted with the broadcast tag.
- R5: Otherwise the frame is accepted with no tag only if its 48-bit destination equals a table entry whose mask bit is set. Table byte i is compared with `frm_dst[8*i+7:8*i]`. A match on a disabled entry is rejected.
- R6: A load started with `ld_start` while idle walks `ld_count[4:0]` descriptors and ignores the upper count bits. Descriptor n fills entry n. Its word 0 is skipped. Words 1, 2 and 3 supply entry bytes {1,0}, {3,2} and {5,4}, with the low byte in `mem_rdata[7:0]`. Word k of a descriptor is at byte address pointer + 2k (`ld_wide`=0) or pointer + 4k (`ld_wide`=1). The pointer starts at `ld_base` and advances 8 or 16 bytes per descriptor.
- R7: After the last descriptor, the word at the advanced pointer becomes the enable mask, with bit n enabling entry n. `ld_busy` then falls and `ld_done` is high for exactly one cycle. A count of zero reads only this word, so a load takes 3·count+1 memory reads.
- R8: While `in_reset` is 1, `rb_data` returns bytes {1,0}, {3,2} or {5,4} of the entry selected by `rb_ptr[3:0]`, for `rb_sel` equal to 0, 1 or 2. Otherwise `rb_data` is 0.
- R9: `dec_valid` is high exactly in the cycle after `frm_valid`. The decision outputs change only then.
- R10: Every decision replaces both tags. A rejected frame, or one accepted by another rule, leaves both tags at 0.
- R11: `ld_start` is ignored while `ld_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Destination and length are valid this cycle |
| frm_dst | input | 48 | Destination address, byte i in bits 8i+7:8i |
| frm_len | input | 16 | Frame length in bytes, CRC excluded |
| mode_runt_ok | input | 1 | Accept short frames |
| mode_promisc | input | 1 | Accept every unicast frame |
| mode_all_mcast | input | 1 | Accept every multicast frame |
| mode_bcast | input | 1 | Accept the broadcast address |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_mcast | output | 1 | Accepted as multicast |
| dec_bcast | output | 1 | Accepted as broadcast |
| ld_start | input | 1 | Start a table load |
| ld_base | input | 16 | Byte address of the first descriptor |
| ld_count | input | 16 | Descriptor count, low 5 bits used |
| ld_wide | input | 1 | Words spaced 4 bytes apart instead of 2 |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle pulse at the end of a load |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Read data |
| in_reset | input | 1 | Receiver is in reset mode |
| rb_ptr | input | 16 | Entry pointer for readback |
| rb_sel | input | 2 | Byte pair select for readback |
| rb_data | output | 16 | Readback data |

## Verification
The bench builds the block with its default parameters: 16 entries, a 60-byte short-frame limit, a 5-bit count and 16-bit addresses. These values let the bench test the boundary at lengths 59 and 60 and fill the full 16-bit mask from one memory word. They also let it set the count and pointer bits above those the block uses, to show those bits are ignored. Loads in both word spacings are checked through the number of memory reads and by reading entries back. Frame vectors run after each load, so the same addresses are checked as enabled, disabled and overwritten.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int BYTE_W    = 8;
   localparam int MAC_BYTES = 6;
   localparam int MAC_W     = BYTE_W * MAC_BYTES;
   localparam int WORD_W    = 16;

   typedef struct packed {
      logic runt_ok;
      logic promisc;
      logic all_mcast;
      logic bcast;
   } rxf_mode_t;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_ENTRY = 2'd1,
      LD_MASK  = 2'd2
   } ld_state_e;
endpackage

// File: rtl/rxf_cam_array.sv
module rxf_cam_array
   import rxf_pkg::*;
#(
   parameter int N_ENT = 16,
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_half,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              mask_we,
   input  logic [N_ENT-1:0]  mask_data,
   input  logic [MAC_W-1:0]  lookup,
   output logic              hit,
   input  logic [IDX_W-1:0]  rd_entry,
   input  logic [1:0]        rd_half,
   output logic [WORD_W-1:0] rd_pair
);
   logic [MAC_W-1:0] ent [N_ENT];
   logic [N_ENT-1:0] en_q;
   logic [N_ENT-1:0] hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (mask_we) en_q <= mask_data;
   end

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent[i] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            case (wr_half)
               2'd0:    ent[i][15:0]  <= wr_data;
               2'd1:    ent[i][31:16] <= wr_data;
               2'd2:    ent[i][47:32] <= wr_data;
               default: ent[i]        <= ent[i];
            endcase
         end
      end
      assign hit_vec[i] = en_q[i] && (ent[i] == lookup);
   end

   assign hit = |hit_vec;

   always_comb begin
      rd_pair = '0;
      if (32'(rd_entry) < N_ENT) begin
         case (rd_half)
            2'd0:    rd_pair = ent[rd_entry][15:0];
            2'd1:    rd_pair = ent[rd_entry][31:16];
            2'd2:    rd_pair = ent[rd_entry][47:32];
            default: rd_pair = '0;
         endcase
      end
   end

   // a hit is only possible once some mask bit has been loaded
   p_hit_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (en_q != '0));
   // a loaded mask takes effect on the next cycle
   p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (en_q == $past(mask_data)));
endmodule

// File: rtl/rxf_cam_loader.sv
module rxf_cam_loader
   import rxf_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 4,
   parameter int N_ENT  = 16,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  count,
   input  logic              wide,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [1:0]        wr_half,
   output logic [WORD_W-1:0] wr_data,
   output logic              mask_we,
   output logic [N_ENT-1:0]  mask_data
);
   localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(16);

   ld_state_e         state_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [1:0]        word_q;
   logic              wide_q;
   logic              done_q;

   assign busy      = (state_q != LD_IDLE);
   assign mem_req   = busy;
   assign mem_addr  = ptr_q + (ADDR_W'(word_q) << (wide_q ? 2 : 1));
   assign wr_en     = (state_q == LD_ENTRY) && mem_ack;
   assign wr_idx    = idx_q;
   assign wr_half   = word_q - 2'd1;
   assign wr_data   = mem_rdata;
   assign mask_we   = (state_q == LD_MASK) && mem_ack;
   assign mask_data = mem_rdata[N_ENT-1:0];
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         ptr_q   <= '0;
         cnt_q   <= '0;
         idx_q   <= '0;
         word_q  <= '0;
         wide_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= mask_we;
         case (state_q)
            LD_IDLE: if (start) begin
               ptr_q   <= base;
               cnt_q   <= count;
               idx_q   <= '0;
               wide_q  <= wide;
               word_q  <= (count != '0) ? 2'd1 : 2'd0;
               state_q <= (count != '0) ? LD_ENTRY : LD_MASK;
            end
            LD_ENTRY: if (mem_ack) begin
               if (word_q == 2'd3) begin
                  cnt_q  <= cnt_q - 1'b1;
                  ptr_q  <= ptr_q + (wide_q ? STEP_WIDE : STEP_NARROW);
                  idx_q  <= idx_q + 1'b1;
                  if (cnt_q == CNT_W'(1)) begin
                     word_q  <= 2'd0;
                     state_q <= LD_MASK;
                  end else begin
                     word_q  <= 2'd1;
                  end
               end else begin
                  word_q <= word_q + 2'd1;
               end
            end
            LD_MASK: if (mem_ack) state_q <= LD_IDLE;
            default: state_q <= LD_IDLE;
         endcase
      end
   end

   p_start_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LD_ENTRY && mem_ack && word_q == 2'd3) |=> (cnt_q == $past(cnt_q) - 1'b1));
   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !mem_ack) |=> ($stable(ptr_q) && $stable(cnt_q) && $stable(word_q)));
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy ##1 !done));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_valid,
   input  logic [MAC_W-1:0] dst,
   input  logic [LEN_W-1:0] len,
   input  rxf_mode_t        mode,
   input  logic             cam_hit,
   output logic             dec_valid,
   output logic             accept,
   output logic             mcast,
   output logic             bcast
);
   logic short_frm, grp_bit, all_ones;
   logic acc_n, mc_n, bc_n;

   assign short_frm = (len < LEN_W'(MIN_LEN));
   assign grp_bit   = dst[0];
   assign all_ones  = &dst;

   always_comb begin
      acc_n = 1'b0;
      mc_n  = 1'b0;
      bc_n  = 1'b0;
      if (short_frm) begin
         acc_n = mode.runt_ok;
      end else if (mode.promisc && !grp_bit) begin
         acc_n = 1'b1;
      end else if (mode.all_mcast && grp_bit) begin
         acc_n = 1'b1;
         mc_n  = 1'b1;
      end else if (mode.bcast && all_ones) begin
         acc_n = 1'b1;
         bc_n  = 1'b1;
      end else begin
         acc_n = cam_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         accept    <= 1'b0;
         mcast     <= 1'b0;
         bcast     <= 1'b0;
      end else begin
         dec_valid <= frm_valid;
         if (frm_valid) begin
            accept <= acc_n;
            mcast  <= mc_n;
            bcast  <= bc_n;
         end
      end
   end

   p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> dec_valid);
   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> (!dec_valid && $stable(accept)));
   p_runt_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && short_frm && !mode.runt_ok) |=> !accept);
   p_tag_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mcast && bcast));
   p_tag_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mcast || bcast) |-> accept);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int N_ENT   = 16,
   parameter int ADDR_W  = 16,
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 60,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_valid,
   input  logic [47:0]        frm_dst,
   input  logic [LEN_W-1:0]   frm_len,
   input  logic               mode_runt_ok,
   input  logic               mode_promisc,
   input  logic               mode_all_mcast,
   input  logic               mode_bcast,
   output logic               dec_valid,
   output logic               dec_accept,
   output logic               dec_mcast,
   output logic               dec_bcast,
   input  logic               ld_start,
   input  logic [ADDR_W-1:0]  ld_base,
   input  logic [15:0]        ld_count,
   input  logic               ld_wide,
   output logic               ld_busy,
   output logic               ld_done,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_ack,
   input  logic [15:0]        mem_rdata,
   input  logic               in_reset,
   input  logic [15:0]        rb_ptr,
   input  logic [1:0]         rb_sel,
   output logic [15:0]        rb_data
);
   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

   initial begin
      assert (N_ENT >= 2 && N_ENT <= WORD_W)
         else $error("N_ENT must fit the one-word enable mask");
      assert (CNT_W >= 1 && CNT_W <= 16)
         else $error("CNT_W out of range");
      assert (MIN_LEN < (1 << LEN_W))
         else $error("MIN_LEN does not fit LEN_W");
   end

   rxf_mode_t        mode;
   logic             cam_hit;
   logic             wr_en, mask_we;
   logic [IDX_W-1:0] wr_idx;
   logic [1:0]       wr_half;
   logic [WORD_W-1:0] wr_data, rd_pair;
   logic [N_ENT-1:0] mask_data;
   logic             unused_hi;

   assign mode      = '{runt_ok: mode_runt_ok, promisc: mode_promisc,
                        all_mcast: mode_all_mcast, bcast: mode_bcast};
   assign unused_hi = ^{ld_count, rb_ptr};

   rxf_cam_loader #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .N_ENT(N_ENT), .CNT_W(CNT_W)) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (ld_start),
      .base      (ld_base),
      .count     (ld_count[CNT_W-1:0]),
      .wide      (ld_wide),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .busy      (ld_busy),
      .done      (ld_done),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_half   (wr_half),
      .wr_data   (wr_data),
      .mask_we   (mask_we),
      .mask_data (mask_data)
   );

   rxf_cam_array #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_cam (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_half   (wr_half),
      .wr_data   (wr_data),
      .mask_we   (mask_we),
      .mask_data (mask_data),
      .lookup    (frm_dst),
      .hit       (cam_hit),
      .rd_entry  (rb_ptr[IDX_W-1:0]),
      .rd_half   (rb_sel),
      .rd_pair   (rd_pair)
   );

   rxf_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_valid (frm_valid),
      .dst       (frm_dst),
      .len       (frm_len),
      .mode      (mode),
      .cam_hit   (cam_hit),
      .dec_valid (dec_valid),
      .accept    (dec_accept),
      .mcast     (dec_mcast),
      .bcast     (dec_bcast)
   );

   assign rb_data = in_reset ? rd_pair : '0;
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic [47:0] frm_dst = '0;
   logic [15:0] frm_len = '0;
   logic        m_runt = 1'b0, m_promisc = 1'b0, m_amc = 1'b0, m_bc = 1'b0;
   logic        dec_valid, dec_accept, dec_mcast, dec_bcast;
   logic        ld_start = 1'b0;
   logic [15:0] ld_base = '0, ld_count = '0;
   logic        ld_wide = 1'b0;
   logic        ld_busy, ld_done, mem_req;
   logic [15:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        in_reset = 1'b0;
   logic [15:0] rb_ptr = '0;
   logic [1:0]  rb_sel = '0;
   logic [15:0] rb_data;

   rx_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_dst(frm_dst), .frm_len(frm_len),
      .mode_runt_ok(m_runt), .mode_promisc(m_promisc), .mode_all_mcast(m_amc), .mode_bcast(m_bc),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_mcast(dec_mcast), .dec_bcast(dec_bcast),
      .ld_start(ld_start), .ld_base(ld_base), .ld_count(ld_count), .ld_wide(ld_wide),
      .ld_busy(ld_busy), .ld_done(ld_done), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .in_reset(in_reset), .rb_ptr(rb_ptr),
      .rb_sel(rb_sel), .rb_data(rb_data)
   );

   // memory model: one word per handshake, acknowledged the cycle after a request
   logic [15:0] mem [256];
   int          n_reads = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else begin
         mem_ack   <= mem_req && !mem_ack;
         mem_rdata <= mem[mem_addr[8:1]];
         if (mem_req && !mem_ack) n_reads <= n_reads + 1;
      end
   end

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   localparam logic [47:0] E0 = 48'h55_44_33_22_11_02;
   localparam logic [47:0] E1 = 48'h0F_0E_0D_0C_0B_0A;
   localparam logic [47:0] E2 = 48'hE0_D0_C0_B0_A0_04;
   localparam logic [47:0] EW = 48'hBB_AA_99_88_77_08;
   localparam logic [47:0] UNI = 48'h10_20_30_40_50_06;
   localparam logic [47:0] MC  = 48'h10_20_30_40_50_01;
   localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

   typedef struct packed {
      logic [47:0] dst;
      logic [15:0] len;
      logic [3:0]  mode;   // {runt_ok, promisc, all_mcast, bcast}
      logic [2:0]  exp;    // {accept, mcast, bcast}
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{E0,   16'd64,  4'b0000, 3'b100, 4'd5},   // R5 enabled entry 0
      '{E1,   16'd64,  4'b0000, 3'b000, 4'd5},   // R5 entry 1 disabled
      '{E2,   16'd64,  4'b0000, 3'b100, 4'd5},   // R5 enabled entry 2
      '{UNI,  16'd64,  4'b0000, 3'b000, 4'd5},   // R5 no match
      '{UNI,  16'd64,  4'b0100, 3'b100, 4'd2},   // R2 promiscuous unicast
      '{E0,   16'd59,  4'b0000, 3'b000, 4'd1},   // R1 short, rejected
      '{E0,   16'd59,  4'b1000, 3'b100, 4'd1},   // R1 short, accepted
      '{MC,   16'd100, 4'b0010, 3'b110, 4'd3},   // R3 multicast tag
      '{MC,   16'd100, 4'b0100, 3'b000, 4'd10},  // R10 tags cleared; R2 promisc skips group
      '{ONES, 16'd100, 4'b0001, 3'b101, 4'd4},   // R4 broadcast tag
      '{ONES, 16'd100, 4'b0011, 3'b110, 4'd3},   // R3 multicast beats broadcast
      '{ONES, 16'd59,  4'b0111, 3'b000, 4'd1},   // R1 short test comes first
      '{E0,   16'd60,  4'b0000, 3'b100, 4'd1}    // R1 boundary 60 not short
   };

   task automatic send(input logic [47:0] d, input logic [15:0] l, input logic [3:0] m,
                       input logic [2:0] exp, input string req);
      @(negedge clk);
      frm_dst = d; frm_len = l;
      {m_runt, m_promisc, m_amc, m_bc} = m;
      frm_valid = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
      chk(dec_valid == 1'b1, {req, " valid"}, 64'(dec_valid), 64'd1);
      chk({dec_accept, dec_mcast, dec_bcast} == exp, req,
          64'({dec_accept, dec_mcast, dec_bcast}), 64'(exp));
   endtask

   task automatic put_entry(input int base, input int stride, input logic [47:0] mac);
      mem[8'((base) >> 1)] = 16'hDEAD;
      for (int k = 1; k <= 3; k++)
         mem[8'((base + k * stride) >> 1)] = mac[16*(k-1) +: 16];
   endtask

   task automatic do_load(input logic [15:0] base, input logic [15:0] cnt, input logic wide,
                          input int exp_reads, input bit poke_mid);
      n_reads = 0;
      @(negedge clk);
      ld_base = base; ld_count = cnt; ld_wide = wide; ld_start = 1'b1;
      @(negedge clk);
      ld_start = 1'b0;
      chk(ld_busy == 1'b1, "R6 busy after start", 64'(ld_busy), 64'd1);
      if (poke_mid) begin
         // R11: a second start with other settings while busy
         repeat (3) @(negedge clk);
         ld_base = 16'h0080; ld_count = 16'h0001; ld_wide = 1'b1; ld_start = 1'b1;
         @(negedge clk);
         ld_start = 1'b0;
      end
      for (int t = 0; t < 200 && ld_busy; t++) @(negedge clk);
      chk(ld_done == 1'b1, "R7 done pulse", 64'(ld_done), 64'd1);
      chk(mem_req == 1'b0, "R7 request dropped", 64'(mem_req), 64'd0);
      chk(n_reads == exp_reads, "R7 read count", 64'(n_reads), 64'(exp_reads));
      @(negedge clk);
      chk(ld_done == 1'b0, "R7 done one cycle", 64'(ld_done), 64'd0);
   endtask

   task automatic rb(input logic [15:0] p, input logic [1:0] s, input logic [15:0] exp, input string req);
      @(negedge clk);
      rb_ptr = p; rb_sel = s;
      #1;
      chk(rb_data == exp, req, 64'(rb_data), 64'(exp));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      // narrow layout at 0x10, 8-byte descriptors, mask word at 0x28
      put_entry(16'h10, 2, E0);
      put_entry(16'h18, 2, E1);
      put_entry(16'h20, 2, E2);
      mem[8'h28 >> 1] = 16'h0005;
      // wide layout at 0x80, 16-byte descriptor, mask word at 0x90
      put_entry(16'h80, 4, EW);
      mem[8'h90 >> 1] = 16'h0001;
      // mask-only load at 0x40
      mem[8'h40 >> 1] = 16'h0004;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dec_valid == 0 && dec_accept == 0, "R9 reset state", 64'({dec_valid, dec_accept}), 64'd0);
      chk(ld_busy == 0 && mem_req == 0, "R7 idle after reset", 64'({ld_busy, mem_req}), 64'd0);

      // R6 narrow walk, count upper bits set, R11 second start ignored
      do_load(16'h0010, 16'h0023, 1'b0, 10, 1'b1);

      in_reset = 1'b1;
      rb(16'h0F01, 2'd0, 16'h0B0A, "R8 entry1 pair0");
      rb(16'h0001, 2'd2, 16'h0F0E, "R8 entry1 pair2");
      rb(16'h0000, 2'd1, 16'h3322, "R8 entry0 pair1");
      rb(16'h0003, 2'd0, 16'h0000, "R8 unloaded entry");
      in_reset = 1'b0;
      rb(16'h0001, 2'd0, 16'h0000, "R8 gated outside reset");

      for (int v = 0; v < NV; v++)
         send(VECS[v].dst, VECS[v].len, VECS[v].mode, VECS[v].exp,
              $sformatf("R%0d vector %0d", VECS[v].req, v));

      // R9 no decision without a frame
      @(negedge clk);
      chk(dec_valid == 1'b0, "R9 no spurious valid", 64'(dec_valid), 64'd0);

      // R6 wide walk overwrites entry 0 only
      do_load(16'h0080, 16'h0001, 1'b1, 4, 1'b0);
      send(EW, 16'd64, 4'b0000, 3'b100, "R6 wide entry hit");
      send(E0, 16'd64, 4'b0000, 3'b000, "R6 old entry replaced");
      send(E2, 16'd64, 4'b0000, 3'b000, "R7 entry 2 now disabled");
      in_reset = 1'b1;
      rb(16'h0002, 2'd2, 16'hE0D0, "R8 entry2 kept");
      rb(16'h0000, 2'd0, 16'h7708, "R6 wide pair0");
      in_reset = 1'b0;

      // R7 count zero: only the mask word is read
      do_load(16'h0040, 16'h0020, 1'b0, 1, 1'b0);
      send(E2, 16'd64, 4'b0000, 3'b100, "R7 mask-only enables entry 2");
      send(EW, 16'd64, 4'b0000, 3'b000, "R7 mask-only disables entry 0");

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule